// File: doc/BRIEF.md
# Dual-Requester DRAM Queue Arbiter

This block sits in front of one DRAM controller command queue that two requesters share: the memory controller on the processor side and the graphics memory controller. Each requester pushes `{write flag, address}` requests into a private 16-entry FIFO. Every cycle the arbiter picks at most one FIFO head and moves it into the DRAM queue through a registered output stage. For each side it keeps a count of requests that were granted and have not yet completed. A side whose count has reached its programmable cap is not eligible.

Two policies are available. The alternating policy (`cfg_policy` = 0, the reset choice) hands grants back and forth between the sides. The fewer-outstanding policy (`cfg_policy` = 1) grants the side with the lower outstanding count and uses the alternation pointer to break ties. An optional override, `cfg_cpu_rd_first`, sends an eligible processor-side read ahead of any graphics request. The alternation pointer is a two-state machine. In `TURN_CPU` the processor side is favoured. A processor grant moves it to `TURN_GFX`, and any other outcome holds it. In `TURN_GFX` a graphics grant moves it back to `TURN_CPU`, and any other outcome holds it. Reset enters `TURN_CPU`.

Top module: `dram_q_arb`

## Requirements
- R1: After reset `dq_valid` is 0, both request-ready outputs are 1, all outstanding counts are 0 and the pointer is in `TURN_CPU`.
- R2: Each request FIFO accepts at most 16 entries; `*_ready` is 0 while it holds 16. Requests from one side leave in arrival order, with `dq_wr` and `dq_addr` equal to the pushed write flag and address.
- R3: A side whose outstanding count is greater than or equal to its cap (`cfg_cpu_cap` / `cfg_gfx_cap`) is not granted; a cap of 0 blocks that side.
- R4: With `cfg_policy` = 0 and both sides eligible, the side named by the pointer is granted; at most one grant is made per cycle.
- R5: With `cfg_policy` = 1 and both sides eligible, the side with the lower outstanding count is granted.
- R6: With `cfg_policy` = 1, both sides eligible and equal counts, the side named by the pointer is granted.
- R7: With `cfg_cpu_rd_first` = 1, an eligible processor-side head whose write flag is 0 is granted whatever the policy and the pointer.
- R8: When exactly one side is eligible, that side is granted whatever the pointer state.
- R9: A side's count rises by one on its grant and falls by one on its `*_done` pulse. A grant and a completion in the same cycle leave it unchanged, and a completion at count 0 leaves it at 0.
- R10: While `dq_full` is 1, nothing is granted, nothing is popped and the pointer holds.
- R11: A grant decided from the state in cycle N shows up on `dq_*` after the edge that ends cycle N. `dq_from_gfx` is 0 for a processor grant and 1 for a graphics grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_policy | input | 1 | 0 alternate, 1 fewer-outstanding |
| cfg_cpu_rd_first | input | 1 | Processor-read override enable |
| cfg_cpu_cap | input | CNT_W (5) | Processor-side outstanding cap |
| cfg_gfx_cap | input | CNT_W (5) | Graphics-side outstanding cap |
| cpu_valid | input | 1 | Processor-side request present |
| cpu_ready | output | 1 | Processor-side FIFO has room |
| cpu_wr | input | 1 | Processor-side request is a write |
| cpu_addr | input | ADDR_W (32) | Processor-side request address |
| gfx_valid | input | 1 | Graphics-side request present |
| gfx_ready | output | 1 | Graphics-side FIFO has room |
| gfx_wr | input | 1 | Graphics-side request is a write |
| gfx_addr | input | ADDR_W (32) | Graphics-side request address |
| dq_full | input | 1 | DRAM queue cannot take a request |
| dq_valid | output | 1 | A request enters the DRAM queue |
| dq_from_gfx | output | 1 | Source of the request (1 graphics) |
| dq_wr | output | 1 | Write flag of the request |
| dq_addr | output | ADDR_W (32) | Address of the request |
| cpu_done | input | 1 | One processor-side request completed |
| gfx_done | input | 1 | One graphics-side request completed |

## Verification
A push accepted at edge N can become a FIFO head from edge N onwards. The grant is decided in cycle N+1 and appears on `dq_*` after edge N+1. Count changes from a grant or a completion at an edge take effect in the eligibility decision of the very next cycle. `*_ready` follows the FIFO fill level after each edge. The bench keeps a queue-based reference that advances at every rising edge from the inputs held stable since the previous falling edge, and compares all outputs at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/dqa_pkg.sv
package dqa_pkg;
    typedef enum logic {TURN_CPU = 1'b0, TURN_GFX = 1'b1} turn_e;
    typedef enum logic {POL_ALTERNATE = 1'b0, POL_FEWER = 1'b1} policy_e;
    localparam int NSIDE   = 2;
    localparam int SIDE_CPU = 0;
    localparam int SIDE_GFX = 1;
endpackage

// File: rtl/dqa_fifo.sv
module dqa_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;

    assign empty = (fill == '0);
    assign full  = (fill == CNT_W'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      fill <= fill + 1'b1;
            else if (!push && pop) fill <= fill - 1'b1;
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) full |-> !push);  // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop); // R2
endmodule

// File: rtl/dqa_outstanding.sv
module dqa_outstanding #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (inc && !dec)                cnt <= cnt + 1'b1;
        else if (!inc && dec && cnt != '0)   cnt <= cnt - 1'b1;
    end

    AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (inc && dec) |=> $stable(cnt)); // R9
    AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
                                     (cnt == '0 && dec && !inc) |=> (cnt == '0));                      // R9
endmodule

// File: rtl/dram_q_arb.sv
module dram_q_arb
    import dqa_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_OUT    = 16,
    localparam int CNT_W     = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_policy,
    input  logic              cfg_cpu_rd_first,
    input  logic [CNT_W-1:0]  cfg_cpu_cap,
    input  logic [CNT_W-1:0]  cfg_gfx_cap,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              gfx_valid,
    output logic              gfx_ready,
    input  logic              gfx_wr,
    input  logic [ADDR_W-1:0] gfx_addr,
    input  logic              dq_full,
    output logic              dq_valid,
    output logic              dq_from_gfx,
    output logic              dq_wr,
    output logic [ADDR_W-1:0] dq_addr,
    input  logic              cpu_done,
    input  logic              gfx_done
);
    localparam int ENT_W = ADDR_W + 1;

    logic [NSIDE-1:0] s_valid, s_push, s_empty, s_full, s_done, s_elig, gnt;
    logic [ENT_W-1:0] s_din  [NSIDE];
    logic [ENT_W-1:0] s_head [NSIDE];
    logic [CNT_W-1:0] s_cnt  [NSIDE];
    logic [CNT_W-1:0] s_cap  [NSIDE];
    turn_e            turn_q, turn_d;
    logic             cpu_head_rd;

    assign s_valid = {gfx_valid, cpu_valid};
    assign s_done  = {gfx_done, cpu_done};
    assign s_din[SIDE_CPU] = {cpu_wr, cpu_addr};
    assign s_din[SIDE_GFX] = {gfx_wr, gfx_addr};
    assign s_cap[SIDE_CPU] = cfg_cpu_cap;
    assign s_cap[SIDE_GFX] = cfg_gfx_cap;
    assign cpu_ready = !s_full[SIDE_CPU];
    assign gfx_ready = !s_full[SIDE_GFX];

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        assign s_push[g] = s_valid[g] && !s_full[g];
        assign s_elig[g] = !s_empty[g] && (s_cnt[g] < s_cap[g]);

        dqa_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(s_push[g]), .din(s_din[g]),
            .pop(gnt[g]), .dout(s_head[g]), .empty(s_empty[g]), .full(s_full[g])
        );

        dqa_outstanding #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(gnt[g]), .dec(s_done[g]), .cnt(s_cnt[g])
        );
    end

    assign cpu_head_rd = !s_head[SIDE_CPU][ADDR_W];

    // State register: alternation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) turn_q <= TURN_CPU;
        else        turn_q <= turn_d;
    end

    // Grant decision and next pointer state
    always_comb begin
        gnt    = '0;
        turn_d = turn_q;
        if (!dq_full) begin
            if (cfg_cpu_rd_first && s_elig[SIDE_CPU] && cpu_head_rd) begin
                gnt = 2'b01;
            end else if (s_elig == 2'b01) begin
                gnt = 2'b01;
            end else if (s_elig == 2'b10) begin
                gnt = 2'b10;
            end else if (s_elig == 2'b11) begin
                if (policy_e'(cfg_policy) == POL_FEWER && s_cnt[SIDE_CPU] != s_cnt[SIDE_GFX])
                    gnt = (s_cnt[SIDE_CPU] < s_cnt[SIDE_GFX]) ? 2'b01 : 2'b10;
                else
                    gnt = (turn_q == TURN_CPU) ? 2'b01 : 2'b10;
            end
        end
        unique case (turn_q)
            TURN_CPU: if (gnt[SIDE_CPU]) turn_d = TURN_GFX;
            TURN_GFX: if (gnt[SIDE_GFX]) turn_d = TURN_CPU;
        endcase
    end

    // Registered hand-off to the DRAM queue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_valid    <= 1'b0;
            dq_from_gfx <= 1'b0;
            dq_wr       <= 1'b0;
            dq_addr     <= '0;
        end else begin
            dq_valid <= |gnt;
            if (|gnt) begin
                dq_from_gfx <= gnt[SIDE_GFX];
                {dq_wr, dq_addr} <= gnt[SIDE_GFX] ? s_head[SIDE_GFX] : s_head[SIDE_CPU];
            end
        end
    end

    AST_ONE_GRANT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));                      // R4
    AST_CPU_CAP:    assert property (@(posedge clk) disable iff (!rst_n) gnt[SIDE_CPU] |-> s_cnt[SIDE_CPU] < cfg_cpu_cap); // R3
    AST_GFX_CAP:    assert property (@(posedge clk) disable iff (!rst_n) gnt[SIDE_GFX] |-> s_cnt[SIDE_GFX] < cfg_gfx_cap); // R3
    AST_FULL_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) dq_full |=> !dq_valid);              // R10
    AST_FULL_TURN:  assert property (@(posedge clk) disable iff (!rst_n) dq_full |=> $stable(turn_q));        // R10
    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                        (!dq_full && cfg_cpu_rd_first && s_elig[SIDE_CPU] && cpu_head_rd)
                        |=> (dq_valid && !dq_from_gfx));                                                     // R7
    AST_SOLO_GFX:   assert property (@(posedge clk) disable iff (!rst_n)
                        (!dq_full && s_elig == 2'b10) |=> (dq_valid && dq_from_gfx));                         // R8
endmodule

// File: tb/dram_q_arb_tb_top.sv
`timescale 1ns/1ps
module dram_q_arb_tb_top;
    localparam int AW = 32;
    localparam int CW = 5;
    localparam int MAXCYC = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_policy = 1'b0, cfg_cpu_rd_first = 1'b0;
    logic [CW-1:0] cfg_cpu_cap = 5'd16, cfg_gfx_cap = 5'd16;
    logic cpu_valid = 1'b0, cpu_wr = 1'b0, gfx_valid = 1'b0, gfx_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0, gfx_addr = '0;
    logic dq_full = 1'b0, cpu_done = 1'b0, gfx_done = 1'b0;
    logic cpu_ready, gfx_ready, dq_valid, dq_from_gfx, dq_wr;
    logic [AW-1:0] dq_addr;

    always #10 clk = ~clk;

    dram_q_arb dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .cfg_cpu_rd_first(cfg_cpu_rd_first),
        .cfg_cpu_cap(cfg_cpu_cap), .cfg_gfx_cap(cfg_gfx_cap),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .gfx_valid(gfx_valid), .gfx_ready(gfx_ready), .gfx_wr(gfx_wr), .gfx_addr(gfx_addr),
        .dq_full(dq_full), .dq_valid(dq_valid), .dq_from_gfx(dq_from_gfx), .dq_wr(dq_wr),
        .dq_addr(dq_addr), .cpu_done(cpu_done), .gfx_done(gfx_done)
    );

    int n_chk = 0, n_bad = 0;
    string cur_req = "R1";
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Behavioural reference: queues, counts, pointer
    logic [AW:0] mq [2][$];
    int mcnt [2];
    int mturn = 0;
    bit e_valid = 0, e_src = 0, e_wr = 0;
    logic [AW-1:0] e_addr = '0;
    int n_cpu_gnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq[0].delete(); mq[1].delete();
            mcnt[0] = 0; mcnt[1] = 0; mturn = 0; e_valid = 0;
        end else begin
            int g;
            bit el0, el1, rd0, rd1;
            logic [AW:0] ent;
            g = -1;
            el0 = mq[0].size() > 0 && mcnt[0] < int'(cfg_cpu_cap);
            el1 = mq[1].size() > 0 && mcnt[1] < int'(cfg_gfx_cap);
            rd0 = mq[0].size() < 16;
            rd1 = mq[1].size() < 16;
            if (!dq_full) begin
                if (cfg_cpu_rd_first && el0 && mq[0][0][AW] == 1'b0) g = 0;
                else if (el0 && !el1) g = 0;
                else if (!el0 && el1) g = 1;
                else if (el0 && el1) begin
                    if (cfg_policy && mcnt[0] != mcnt[1]) g = (mcnt[0] < mcnt[1]) ? 0 : 1;
                    else g = mturn;
                end
            end
            if (g >= 0) begin
                ent = mq[g].pop_front();
                e_valid = 1; e_src = g[0]; e_wr = ent[AW]; e_addr = ent[AW-1:0];
                if (g == mturn) mturn = 1 - g;
            end else e_valid = 0;
            if (cpu_valid && rd0) mq[0].push_back({cpu_wr, cpu_addr});
            if (gfx_valid && rd1) mq[1].push_back({gfx_wr, gfx_addr});
            for (int s = 0; s < 2; s++) begin
                bit inc, dec;
                inc = (g == s);
                dec = (s == 0) ? cpu_done : gfx_done;
                if (inc && !dec) mcnt[s]++;
                else if (!inc && dec && mcnt[s] > 0) mcnt[s]--;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(dq_valid == e_valid, "dq_valid", dq_valid, e_valid);
            if (e_valid && dq_valid) begin
                chk(dq_from_gfx == e_src, "dq_from_gfx", dq_from_gfx, e_src);
                chk(dq_wr == e_wr, "dq_wr", dq_wr, e_wr);
                chk(dq_addr == e_addr, "dq_addr", dq_addr, e_addr);
            end
            chk(cpu_ready == (mq[0].size() < 16), "cpu_ready", cpu_ready, mq[0].size() < 16);
            chk(gfx_ready == (mq[1].size() < 16), "gfx_ready", gfx_ready, mq[1].size() < 16);
            if (dq_valid && !dq_from_gfx) n_cpu_gnt++;
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle();
        cpu_valid = 0; gfx_valid = 0; cpu_done = 0; gfx_done = 0; dq_full = 0;
    endtask

    // Load n requests on each selected side while the queue is held full
    task automatic load(input int nc, input int ng, input bit cw, input bit gw, input int base);
        dq_full = 1;
        for (int i = 0; i < 16; i++) begin
            cpu_valid = (i < nc); cpu_wr = cw; cpu_addr = base + i;
            gfx_valid = (i < ng); gfx_wr = gw; gfx_addr = base + 32'h1000 + i;
            if (i >= nc && i >= ng) break;
            cyc();
        end
        cpu_valid = 0; gfx_valid = 0;
        cyc();
    endtask

    task automatic drain_counts();
        idle(); cpu_done = 1; gfx_done = 1; dq_full = 1;
        cyc(20);
        idle();
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        cur_req = "R1";
        chk(dq_valid == 0, "reset dq_valid", dq_valid, 0);
        chk(cpu_ready == 1, "reset cpu_ready", cpu_ready, 1);
        chk(gfx_ready == 1, "reset gfx_ready", gfx_ready, 1);

        cur_req = "R2";
        dq_full = 1;
        for (int i = 0; i < 18; i++) begin
            cpu_valid = 1; cpu_wr = i[0]; cpu_addr = 32'hA000 + i;
            cyc();
        end
        cpu_valid = 0;
        chk(cpu_ready == 0, "full fifo ready", cpu_ready, 0);
        idle(); cpu_done = 1;
        cyc(20);
        chk(cpu_ready == 1, "drained ready", cpu_ready, 1);
        drain_counts();

        cur_req = "R4";
        load(6, 6, 1, 1, 32'hB000);
        dq_full = 0; cpu_done = 1; gfx_done = 1;
        cyc(14);
        drain_counts();

        cur_req = "R3";
        cfg_cpu_cap = 2;
        load(5, 5, 1, 1, 32'hC000);
        n_cpu_gnt = 0;
        dq_full = 0;
        cyc(12);
        chk(n_cpu_gnt == 2, "cpu grants at cap", n_cpu_gnt, 2);
        cfg_cpu_cap = 0;
        cpu_done = 1; cyc(4); cpu_done = 0;
        n_cpu_gnt = 0; cyc(4);
        chk(n_cpu_gnt == 0, "cap zero blocks", n_cpu_gnt, 0);
        cfg_cpu_cap = 16;
        cyc(6);
        drain_counts();

        cur_req = "R5";
        cfg_policy = 1;
        load(3, 0, 0, 0, 32'hD000);
        dq_full = 0; cyc(5);
        load(4, 4, 0, 1, 32'hD100);
        dq_full = 0; cyc(10);
        cur_req = "R6";
        drain_counts();
        load(4, 4, 1, 0, 32'hD200);
        dq_full = 0; cyc(10);
        drain_counts();

        cur_req = "R7";
        cfg_policy = 0; cfg_cpu_rd_first = 1;
        load(5, 5, 0, 1, 32'hE000);
        dq_full = 0; cpu_done = 1; gfx_done = 1; cyc(12);
        load(3, 3, 1, 1, 32'hE100);
        dq_full = 0; cyc(8);
        cfg_cpu_rd_first = 0;
        drain_counts();

        cur_req = "R8";
        load(0, 4, 0, 0, 32'hF000);
        dq_full = 0; gfx_done = 1; cyc(6);
        drain_counts();

        cur_req = "R9";
        cfg_cpu_cap = 1;
        load(8, 0, 0, 0, 32'h1100);
        n_cpu_gnt = 0;
        dq_full = 0; cpu_done = 1;
        cyc(9);
        chk(n_cpu_gnt == 8, "grant+done keeps count", n_cpu_gnt, 8);
        cfg_cpu_cap = 16;
        drain_counts();

        cur_req = "R10";
        load(8, 8, 0, 1, 32'h2200);
        for (int i = 0; i < 40; i++) begin
            dq_full = i[1] ^ i[0]; cpu_done = 1; gfx_done = 1;
            cyc();
        end
        drain_counts();

        cur_req = "R11";
        for (int i = 0; i < 4000; i++) begin
            cpu_valid = $urandom_range(0, 1); cpu_wr = $urandom_range(0, 1); cpu_addr = $urandom;
            gfx_valid = $urandom_range(0, 1); gfx_wr = $urandom_range(0, 1); gfx_addr = $urandom;
            dq_full = ($urandom_range(0, 3) == 0);
            cpu_done = $urandom_range(0, 1); gfx_done = $urandom_range(0, 1);
            if (i % 250 == 0) begin
                cfg_policy = $urandom_range(0, 1); cfg_cpu_rd_first = $urandom_range(0, 1);
                cfg_cpu_cap = $urandom_range(0, 16); cfg_gfx_cap = $urandom_range(0, 16);
            end
            cyc();
        end
        idle();
        cyc(2);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(MAXCYC * 20);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule